// File: doc/BRIEF.md
# Masked Bit Partition Unit

This block splits a data word into two groups chosen by a mask word and returns both groups in one result word. Bits whose mask bit is set move to the upper end of the result; bits whose mask bit is clear move to the lower end. Nothing is discarded, so the result is always a rearrangement of the input bits.

A mode input chooses how the low group is ordered. By default both groups keep the relative order they had in the input, which makes this a stable partition. In reversed mode the low group is written in the opposite order. With that option, a short chain of passes can produce any rearrangement of the word's bits, roughly one pass for each bit of the word's index. The operands arrive through a valid/ready handshake. The result is registered and appears, with a valid flag, on the clock after the handshake.

Top module: `bit_partition`

## Requirements
- R1: An input bit whose mask bit is 1 lands in the top k positions of the result, where k is the number of ones in the mask. The selected bit with the lowest input index lands at position W-k. The remaining selected bits follow upward in input order.
- R2: With the mode input low, an input bit whose mask bit is 0 lands in the bottom W-k positions. The unselected bit with the lowest input index lands at position 0, and the rest follow upward in input order.
- R3: With the mode input high, the unselected bits fill the bottom W-k positions in reversed order. The unselected bit with the lowest input index lands at position W-k-1, and the one with the highest input index lands at position 0.
- R4: The number of ones in every result equals the number of ones in the data word it came from.
- R5: out_valid is high on exactly the cycle after a clock edge at which in_valid and in_ready were both high. When no operand is accepted, out_data keeps its previous value.
- R6: A mask of all ones returns the data word unchanged in either mode.
- R7: A mask of all zeros returns the data word unchanged with the mode input low, and the data word bit-reversed with it high.
- R8: While rst_n is low, out_valid, in_ready and out_data are all 0. After reset is released, in_ready goes high from the first clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present |
| in_ready | output | 1 | Block can accept operands |
| in_data | input | W | Word to be partitioned |
| in_mask | input | W | Selects the bits sent to the upper end |
| in_rev_low | input | 1 | 1 reverses the order of the unselected group |
| out_valid | output | 1 | out_data holds a fresh result this cycle |
| out_data | output | W | Registered partitioned word |

## Verification
On every cycle, the in-module assertions check that the result keeps the input's population count. They also check the one-cycle timing of out_valid, that the result holds steady between accepted operands, and that the all-ones and all-zeros mask cases give the identity or the bit reversal. The exact placement of each bit within the two groups, in both modes, can only be shown by the bench. The bench compares every result against a queue-based reference model, using directed masks such as a single set bit, a single clear bit, alternating patterns and half-word splits, and random masks of several densities, with idle gaps between some operations.

// File: rtl/bit_partition.sv
module bit_partition #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic [W-1:0] in_mask,
  input  logic         in_rev_low,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic         rdy_q;
  logic         vld_q;
  logic [W-1:0] res_q;
  logic [W-1:0] part;
  logic         take;

  assign take      = in_valid && rdy_q;
  assign in_ready  = rdy_q;
  assign out_valid = vld_q;
  assign out_data  = res_q;

  always_comb begin
    int k;
    int hi_n;
    int lo_n;
    logic [IW-1:0] pos;
    k    = $countones(in_mask);
    hi_n = 0;
    lo_n = 0;
    pos  = '0;
    part = '0;
    for (int i = 0; i < W; i++) begin
      if (in_mask[i]) begin
        pos = IW'(W - k + hi_n);
        hi_n++;
      end else begin
        pos = in_rev_low ? IW'(W - k - 1 - lo_n) : IW'(lo_n);
        lo_n++;
      end
      part[pos] = in_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      vld_q <= take;
      if (take) res_q <= part;
    end
  end

  a_r4_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($countones(out_data) == $countones($past(in_data))));

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !out_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(out_data));

  a_r6_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (&in_mask)) |=> (out_data == $past(in_data)));

  a_r7_zero_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_mask == '0) && !in_rev_low) |=> (out_data == $past(in_data)));

  a_r7_zero_rev: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_mask == '0) && in_rev_low) |=> (out_data == {<<{$past(in_data)}}));

  always_comb begin
    if (!rst_n) a_r8_reset_quiet: assert (!vld_q && !rdy_q && res_q == '0);
  end
endmodule

// File: tb/sim_bit_partition.sv
module sim_bit_partition;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] in_mask = '0;
  logic         in_rev_low = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_data;

  always #2 clk = ~clk;

  bit_partition #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mask(in_mask), .in_rev_low(in_rev_low),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic         exp_v = 1'b0;
  logic [W-1:0] exp_d = '0;
  logic [W-1:0] exp_src = '0;
  string        exp_tag = "R1";

  function automatic logic [W-1:0] model(logic [W-1:0] d, logic [W-1:0] m, bit rev);
    bit hi_q[$];
    bit lo_q[$];
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      if (m[i]) hi_q.push_back(d[i]);
      else      lo_q.push_back(d[i]);
    end
    for (int j = 0; j < lo_q.size(); j++)
      r[rev ? (lo_q.size() - 1 - j) : j] = lo_q[j];
    for (int j = 0; j < hi_q.size(); j++)
      r[lo_q.size() + j] = hi_q[j];
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(bit v, logic [W-1:0] d, logic [W-1:0] m, bit rev, string tag,
                      bit ovr = 1'b0, logic [W-1:0] ovr_val = '0);
    @(negedge clk);
    check("R5 valid", W'(out_valid), W'(exp_v));
    if (exp_v) begin
      check(exp_tag, out_data, exp_d);
      check("R4 popcount", W'($countones(out_data)), W'($countones(exp_src)));
    end else begin
      check("R5 hold", out_data, exp_d);
    end
    in_valid   = v;
    in_data    = d;
    in_mask    = m;
    in_rev_low = rev;
    exp_v      = v;
    if (v) begin
      exp_src = d;
      exp_d   = ovr ? ovr_val : model(d, m, rev);
      exp_tag = tag;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] m;
    repeat (3) @(negedge clk);
    check("R8 reset valid", W'(out_valid), '0);
    check("R8 reset ready", W'(in_ready), '0);
    check("R8 reset data", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 ready after reset", W'(in_ready), W'(1));

    // R6: mask of all ones, both modes
    step(1, 32'hDEADBEEF, '1, 0, "R6 ones fwd", 1, 32'hDEADBEEF);
    step(1, 32'h12345678, '1, 1, "R6 ones rev", 1, 32'h12345678);
    // R7: mask of all zeros
    step(1, 32'hA5C30F81, '0, 0, "R7 zeros fwd", 1, 32'hA5C30F81);
    step(1, 32'hA5C30F81, '0, 1, "R7 zeros rev", 1, {<<{32'hA5C30F81}});
    // R1: single selected bit goes to the top
    step(1, 32'h0000_0001, 32'h0000_0001, 0, "R1 single lsb", 1, 32'h8000_0000);
    step(1, 32'h0000_0100, 32'h0000_0100, 0, "R1 single mid", 1, 32'h8000_0000);
    // R2: single unselected bit goes to the bottom
    step(1, 32'h8000_0000, 32'h7FFF_FFFF, 0, "R2 single clear", 1, 32'h0000_0001);
    // R1/R2: half-word split swaps halves
    step(1, 32'hABCD_1234, 32'h0000_FFFF, 0, "R1 half swap", 1, 32'h1234_ABCD);
    // R3: reversed low group on a half split
    step(1, 32'hABCD_1234, 32'h0000_FFFF, 1, "R3 half swap rev", 1, {16'h1234, {<<{16'hABCD}}});
    step(0, '0, '0, 0, "R5");
    step(0, 32'hFFFF_FFFF, 32'h5555_5555, 1, "R5");
    step(1, 32'hF0F0_F0F0, 32'h5555_5555, 0, "R1 alternating");
    step(1, 32'hF0F0_F0F0, 32'hAAAA_AAAA, 1, "R3 alternating");

    for (int n = 0; n < 400; n++) begin
      d = $urandom;
      case (n % 4)
        0: m = $urandom;
        1: m = $urandom & $urandom;
        2: m = $urandom | $urandom;
        default: m = 32'h1 << (n % W);
      endcase
      step(($urandom % 5) != 0, d, m, n[1], n[1] ? "R3 random" : "R2 random");
    end
    step(0, '0, '0, 0, "R5");
    step(0, '0, '0, 0, "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule